// File: doc/BRIEF.md
# USB Host Command and Interrupt Status Register Pair

This block holds two 32-bit registers of a USB host controller. The command register latches requests from software: a controller reset, two "list has work" flags (one for control transfers, one for bulk transfers) and a request to hand ownership of the controller over. The interrupt register collects sticky status bits. Single-cycle event pulses from the rest of the controller set these bits. Software clears a bit by writing 1 to it.

Software reaches both registers through a plain register port. The port has an address, write data, byte enables, a write strobe and a read strobe, and its read data is combinational. The outputs are the pending reset request, the two list flags, the ownership request and one interrupt line. The interrupt line is the OR of every status bit masked by a per-bit enable vector.

The reset request is held by a two-state machine:
- **RST_IDLE**: no reset is pending. The transition *start* (a software write of 1 to command bit 0) moves it to RST_BUSY.
- **RST_BUSY**: `req_reset` is driven high. The transition *done* (`ack_reset_done`) returns it to RST_IDLE. A write of 1 while busy has no further effect.

Top module: `usbh_cmdint_regs`

## Requirements
- R1: After reset every output is 0. Both registers read 0. The command register is at offset 08h and the interrupt register at 0Ch. `reg_rdata` is 0 when `reg_rd` is low or the address matches neither register.
- R2: Writing 1 to command bit 0 (with byte enable 0) raises `req_reset` on the next cycle. It stays high until the cycle after `ack_reset_done`, and bit 0 reads back the same level.
- R3: Command bits 1 (control list filled) and 2 (bulk list filled) are set by a software write of 1 or by the pulses `hw_ctrl_fill` / `hw_bulk_fill`. They are cleared by `ack_ctrl_head` / `ack_bulk_head`. If a set and a clear arrive in the same cycle, the set wins. Writing 0 to these bits has no effect.
- R4: Command bit 3 (ownership request) takes the written value whenever byte 0 is written. Every write of 1 to it also sets interrupt bit 30.
- R5: Command bits 17:16 count scheduling overrun pulses modulo 4 (3 wraps to 0). Writes to these bits have no effect.
- R6: Interrupt bits 0 (scheduling overrun), 1 (done-head writeback), 2 (start of frame) and 3 (resume detected) are set by their event pulses.
- R7: Interrupt bit 4 always reads 0, and writes to it have no effect.
- R8: Interrupt bit 5 is set on any change of the `frame_msb` input, whether it rises or falls.
- R9: Interrupt bit 6 is set by the `evt_rh_change` pulse.
- R10: Writing 1 to an interrupt bit clears it, and writing 0 leaves it unchanged. Only the bytes whose byte enable is high take part in the clear. If an event and a clear hit the same bit in the same cycle, the bit ends up set. Reserved bits read 0.
- R11: `irq` is high exactly when some interrupt bit is set and its `int_enable` bit is high.
- R12: A command write with byte enable 0 low leaves bits 3:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Write byte enables |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data (combinational) |
| evt_sched_overrun | input | 1 | Scheduling overrun pulse |
| evt_done_writeback | input | 1 | Done-head writeback pulse |
| evt_sof | input | 1 | Start-of-frame pulse |
| evt_resume | input | 1 | Resume detected pulse |
| evt_rh_change | input | 1 | Root hub status change pulse |
| frame_msb | input | 1 | Most significant bit of the frame number |
| hw_ctrl_fill | input | 1 | Hardware sets control list filled |
| hw_bulk_fill | input | 1 | Hardware sets bulk list filled |
| ack_ctrl_head | input | 1 | Control list head processing started |
| ack_bulk_head | input | 1 | Bulk list head processing started |
| ack_reset_done | input | 1 | Controller reset completed |
| int_enable | input | 32 | Per-bit interrupt enables |
| req_reset | output | 1 | Reset request pending |
| ctrl_filled | output | 1 | Control list filled flag |
| bulk_filled | output | 1 | Bulk list filled flag |
| owner_req | output | 1 | Ownership change request |
| irq | output | 1 | Combined interrupt |

## Verification
Every stored result follows its stimulus by one clock: a write, event pulse, acknowledge or `frame_msb` change applied before an edge is visible in the register state just after that edge. Read data and `irq` are combinational from that state, so a read issued in a cycle shows the state as of the last edge. Stimulus is applied just after the rising edge. A behavioural model advances on each rising edge, and every output, plus the read data whenever a read is strobed, is compared against it on the falling edge, one full cycle after the stimulus.

// File: rtl/usbh_cmdint_pkg.sv
package usbh_cmdint_pkg;
    localparam int            REG_W      = 32;
    localparam int            OFS_W      = 8;
    localparam logic [7:0]    CMD_OFS    = 8'h08;
    localparam logic [7:0]    INT_OFS    = 8'h0C;

    // command register bit positions
    localparam int CMD_RST   = 0;
    localparam int CMD_CTRL  = 1;
    localparam int CMD_BULK  = 2;
    localparam int CMD_OWN   = 3;
    localparam int CMD_CNT_LO = 16;

    // interrupt register bit positions
    localparam int IST_OVR   = 0;
    localparam int IST_WDH   = 1;
    localparam int IST_SOF   = 2;
    localparam int IST_RES   = 3;
    localparam int IST_UE    = 4;
    localparam int IST_FNO   = 5;
    localparam int IST_RHC   = 6;
    localparam int IST_OWN   = 30;

    localparam logic [REG_W-1:0] IST_IMPL = (32'h1 << IST_OVR) | (32'h1 << IST_WDH)
                                          | (32'h1 << IST_SOF) | (32'h1 << IST_RES)
                                          | (32'h1 << IST_FNO) | (32'h1 << IST_RHC)
                                          | (32'h1 << IST_OWN);

    typedef enum logic [0:0] {
        RST_IDLE = 1'b0,
        RST_BUSY = 1'b1
    } rst_state_e;
endpackage

// File: rtl/usbh_reset_seq.sv
module usbh_reset_seq
    import usbh_cmdint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic busy
);
    rst_state_e state_q;
    rst_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_IDLE: if (start) state_d = RST_BUSY;
            RST_BUSY: if (done)  state_d = RST_IDLE;
            default:             state_d = RST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == RST_BUSY);
    end
endmodule

// File: rtl/usbh_cmd_status.sv
module usbh_cmd_status #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_b0,
    input  logic [3:0]       wd_b0,
    input  logic [1:0]       hw_fill,
    input  logic [1:0]       head_ack,
    input  logic             ovr_evt,
    output logic [1:0]       list_q,
    output logic             own_q,
    output logic             own_evt,
    output logic [CNT_W-1:0] cnt_q
);
    localparam int LISTS = 2;

    for (genvar g = 0; g < LISTS; g++) begin : g_list
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if ((wr_b0 && wd_b0[g+1]) || hw_fill[g]) begin
                flag_q <= 1'b1;
            end else if (head_ack[g]) begin
                flag_q <= 1'b0;
            end
        end
        assign list_q[g] = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= 1'b0;
        end else if (wr_b0) begin
            own_q <= wd_b0[3];
        end
    end

    assign own_evt = wr_b0 && wd_b0[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ovr_evt) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/usbh_int_status.sv
module usbh_int_status
    import usbh_cmdint_pkg::*;
#(
    parameter int              W    = 32,
    parameter logic [W-1:0]    IMPL = '1,
    parameter int              TOG_BIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         frame_msb,
    output logic [W-1:0] stat_q
);
    logic         msb_q;
    logic [W-1:0] set_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msb_q <= 1'b0;
        end else begin
            msb_q <= frame_msb;
        end
    end

    always_comb begin
        set_all          = set_vec;
        set_all[TOG_BIT] = set_vec[TOG_BIT] | (frame_msb ^ msb_q);
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            logic b_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    b_q <= 1'b0;
                end else if (set_all[i]) begin
                    b_q <= 1'b1;
                end else if (clr_vec[i]) begin
                    b_q <= 1'b0;
                end
            end
            assign stat_q[i] = b_q;
        end else begin : g_tied
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/usbh_cmdint_regs.sv
module usbh_cmdint_regs
    import usbh_cmdint_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_be,
    input  logic        reg_wr,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    input  logic        evt_sched_overrun,
    input  logic        evt_done_writeback,
    input  logic        evt_sof,
    input  logic        evt_resume,
    input  logic        evt_rh_change,
    input  logic        frame_msb,
    input  logic        hw_ctrl_fill,
    input  logic        hw_bulk_fill,
    input  logic        ack_ctrl_head,
    input  logic        ack_bulk_head,
    input  logic        ack_reset_done,
    input  logic [31:0] int_enable,
    output logic        req_reset,
    output logic        ctrl_filled,
    output logic        bulk_filled,
    output logic        owner_req,
    output logic        irq
);
    localparam int BYTES = REG_W / 8;

    logic             wr_cmd;
    logic             wr_int;
    logic             wr_cmd_b0;
    logic [REG_W-1:0] be_mask;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] int_q;
    logic [1:0]       list_q;
    logic             own_evt;
    logic [CNT_W-1:0] ovr_cnt;
    logic             busy;

    assign wr_cmd    = reg_wr && (reg_addr == CMD_OFS);
    assign wr_int    = reg_wr && (reg_addr == INT_OFS);
    assign wr_cmd_b0 = wr_cmd && reg_be[0];

    for (genvar b = 0; b < BYTES; b++) begin : g_bemask
        assign be_mask[b*8 +: 8] = {8{reg_be[b]}};
    end

    assign clr_vec = wr_int ? (reg_wdata & be_mask) : '0;

    always_comb begin
        set_vec          = '0;
        set_vec[IST_OVR] = evt_sched_overrun;
        set_vec[IST_WDH] = evt_done_writeback;
        set_vec[IST_SOF] = evt_sof;
        set_vec[IST_RES] = evt_resume;
        set_vec[IST_RHC] = evt_rh_change;
        set_vec[IST_OWN] = own_evt;
    end

    usbh_reset_seq u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_cmd_b0 && reg_wdata[CMD_RST]),
        .done  (ack_reset_done),
        .busy  (busy)
    );

    usbh_cmd_status #(.CNT_W(CNT_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_b0    (wr_cmd_b0),
        .wd_b0    (reg_wdata[3:0]),
        .hw_fill  ({hw_bulk_fill, hw_ctrl_fill}),
        .head_ack ({ack_bulk_head, ack_ctrl_head}),
        .ovr_evt  (evt_sched_overrun),
        .list_q   (list_q),
        .own_q    (owner_req),
        .own_evt  (own_evt),
        .cnt_q    (ovr_cnt)
    );

    usbh_int_status #(.W(REG_W), .IMPL(IST_IMPL), .TOG_BIT(IST_FNO)) u_int (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .frame_msb (frame_msb),
        .stat_q    (int_q)
    );

    assign req_reset   = busy;
    assign ctrl_filled = list_q[0];
    assign bulk_filled = list_q[1];
    assign irq         = |(int_q & int_enable);

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == CMD_OFS) begin
                reg_rdata[CMD_RST]                  = busy;
                reg_rdata[CMD_CTRL]                 = list_q[0];
                reg_rdata[CMD_BULK]                 = list_q[1];
                reg_rdata[CMD_OWN]                  = owner_req;
                reg_rdata[CMD_CNT_LO +: CNT_W]      = ovr_cnt;
            end else if (reg_addr == INT_OFS) begin
                reg_rdata = int_q;
            end
        end
    end
endmodule

// File: rtl/usbh_cmdint_regs_chk.sv
module usbh_cmdint_regs_chk
    import usbh_cmdint_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [3:0]       reg_be,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [31:0]      reg_rdata,
    input logic             evt_sof,
    input logic             evt_sched_overrun,
    input logic             hw_ctrl_fill,
    input logic             ack_reset_done,
    input logic [31:0]      int_enable,
    input logic             req_reset,
    input logic             ctrl_filled,
    input logic             irq,
    input logic [CNT_W-1:0] ovr_cnt,
    input logic [31:0]      int_q
);
    // R2: pending reset request holds until acknowledged
    a_r2_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset && !ack_reset_done |=> req_reset);

    // R2: acknowledge releases the request
    a_r2_ack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset && ack_reset_done |=> !req_reset);

    // R3: hardware fill wins over a same-cycle head acknowledge
    a_r3_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hw_ctrl_fill |=> ctrl_filled);

    // R4: writing 1 to the ownership bit raises interrupt bit 30
    a_r4_owner_int: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == CMD_OFS && reg_be[0] && reg_wdata[CMD_OWN]
        |=> int_q[IST_OWN]);

    // R5: overrun counter advances by one, wrapping
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sched_overrun |=> ovr_cnt == CNT_W'($past(ovr_cnt) + 1'b1));

    // R7: unrecoverable error bit never reads as 1
    a_r7_bit4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == INT_OFS |-> !reg_rdata[IST_UE]);

    // R11: an enabled start-of-frame event raises irq
    a_r11_sof_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_sof) && int_enable[IST_SOF] |-> irq);
endmodule

bind usbh_cmdint_regs usbh_cmdint_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .reg_addr          (reg_addr),
    .reg_wdata         (reg_wdata),
    .reg_be            (reg_be),
    .reg_wr            (reg_wr),
    .reg_rd            (reg_rd),
    .reg_rdata         (reg_rdata),
    .evt_sof           (evt_sof),
    .evt_sched_overrun (evt_sched_overrun),
    .hw_ctrl_fill      (hw_ctrl_fill),
    .ack_reset_done    (ack_reset_done),
    .int_enable        (int_enable),
    .req_reset         (req_reset),
    .ctrl_filled       (ctrl_filled),
    .irq               (irq),
    .ovr_cnt           (ovr_cnt),
    .int_q             (int_q)
);

// File: tb/usbh_cmdint_regs_test.sv
module usbh_cmdint_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        evt_sched_overrun = 0, evt_done_writeback = 0, evt_sof = 0;
    logic        evt_resume = 0, evt_rh_change = 0, frame_msb = 0;
    logic        hw_ctrl_fill = 0, hw_bulk_fill = 0;
    logic        ack_ctrl_head = 0, ack_bulk_head = 0, ack_reset_done = 0;
    logic [31:0] int_enable = '0;
    logic        req_reset, ctrl_filled, bulk_filled, owner_req, irq;

    always #2 clk = ~clk;

    usbh_cmdint_regs uut (.*);

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // behavioural reference
    logic        m_rst = 0, m_ctrl = 0, m_bulk = 0, m_own = 0, m_fq = 0;
    int          m_cnt = 0;
    logic [31:0] m_ist = '0;
    logic [31:0] m_clr, m_set;
    logic        m_wc, m_wi, m_oevt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rst = 0; m_ctrl = 0; m_bulk = 0; m_own = 0; m_fq = 0;
            m_cnt = 0; m_ist = '0;
        end else begin
            m_wc   = reg_wr && reg_addr == 8'h08 && reg_be[0];
            m_wi   = reg_wr && reg_addr == 8'h0C;
            m_oevt = m_wc && reg_wdata[3];
            if (m_rst) begin
                if (ack_reset_done) m_rst = 0;
            end else if (m_wc && reg_wdata[0]) begin
                m_rst = 1;
            end
            if ((m_wc && reg_wdata[1]) || hw_ctrl_fill) m_ctrl = 1;
            else if (ack_ctrl_head) m_ctrl = 0;
            if ((m_wc && reg_wdata[2]) || hw_bulk_fill) m_bulk = 1;
            else if (ack_bulk_head) m_bulk = 0;
            if (m_wc) m_own = reg_wdata[3];
            if (evt_sched_overrun) m_cnt = (m_cnt + 1) % 4;
            m_set = '0;
            m_set[0]  = evt_sched_overrun;
            m_set[1]  = evt_done_writeback;
            m_set[2]  = evt_sof;
            m_set[3]  = evt_resume;
            m_set[5]  = (frame_msb != m_fq);
            m_set[6]  = evt_rh_change;
            m_set[30] = m_oevt;
            m_fq = frame_msb;
            m_clr = '0;
            if (m_wi) begin
                for (int b = 0; b < 4; b++)
                    if (reg_be[b]) m_clr[b*8 +: 8] = reg_wdata[b*8 +: 8];
            end
            m_ist = (m_ist & ~m_clr) | m_set;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v = '0;
        if (reg_rd) begin
            if (reg_addr == 8'h08) begin
                v[0] = m_rst; v[1] = m_ctrl; v[2] = m_bulk; v[3] = m_own;
                v[17:16] = 2'(m_cnt);
            end else if (reg_addr == 8'h0C) begin
                v = m_ist;
            end
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2",  {31'b0, req_reset},   {31'b0, m_rst});
            chk("R3",  {31'b0, ctrl_filled}, {31'b0, m_ctrl});
            chk("R3",  {31'b0, bulk_filled}, {31'b0, m_bulk});
            chk("R4",  {31'b0, owner_req},   {31'b0, m_own});
            chk("R11", {31'b0, irq},         {31'b0, |(m_ist & int_enable)});
            if (reg_rd) chk(cur_tag, reg_rdata, exp_rdata());
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        reg_wr = 0; reg_rd = 0;
        evt_sched_overrun = 0; evt_done_writeback = 0; evt_sof = 0;
        evt_resume = 0; evt_rh_change = 0;
        hw_ctrl_fill = 0; hw_bulk_fill = 0;
        ack_ctrl_head = 0; ack_bulk_head = 0; ack_reset_done = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
        tick();
    endtask

    task automatic rd(logic [7:0] a, string tag);
        cur_tag = tag; reg_rd = 1; reg_addr = a;
        tick();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", {27'b0, req_reset, ctrl_filled, bulk_filled, owner_req, irq}, 32'b0);
        @(posedge clk); #1;
        rd(8'h08, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1");

        // R2: reset request until acknowledge
        wr(8'h08, 32'h1, 4'b0001);
        tick(); tick();
        rd(8'h08, "R2");
        wr(8'h08, 32'h1, 4'b0001);
        ack_reset_done = 1; tick();
        tick(); rd(8'h08, "R2");

        // R12: byte 0 disabled leaves bits 3:0 alone
        wr(8'h08, 32'hF, 4'b1110);
        rd(8'h08, "R12");

        // R3: list flags, set beats acknowledge
        wr(8'h08, 32'h6, 4'b0001);
        rd(8'h08, "R3");
        ack_ctrl_head = 1; tick();
        hw_bulk_fill = 1; ack_bulk_head = 1; tick();
        rd(8'h08, "R3");
        wr(8'h08, 32'h0, 4'b0001);
        rd(8'h08, "R3");
        hw_ctrl_fill = 1; ack_ctrl_head = 1; tick();
        ack_bulk_head = 1; tick();
        rd(8'h08, "R3");

        // R4: ownership request and its interrupt
        wr(8'h08, 32'h8, 4'b0001);
        rd(8'h0C, "R4");
        wr(8'h08, 32'h0, 4'b0001);
        rd(8'h08, "R4"); rd(8'h0C, "R4");

        // R10: clear needs byte 3 enabled
        wr(8'h0C, 32'h4000_0000, 4'b0111);
        rd(8'h0C, "R10");
        wr(8'h0C, 32'h4000_0000, 4'b1000);
        rd(8'h0C, "R10");

        // R5: overrun count wraps modulo 4, writes ignored
        for (int i = 0; i < 5; i++) begin
            evt_sched_overrun = 1; tick();
        end
        rd(8'h08, "R5");
        wr(8'h08, 32'h0003_0000, 4'b1111);
        rd(8'h08, "R5");

        // R6 / R9: event bits
        evt_done_writeback = 1; tick();
        evt_sof = 1; tick();
        evt_resume = 1; tick();
        rd(8'h0C, "R6");
        evt_rh_change = 1; tick();
        rd(8'h0C, "R9");
        wr(8'h0C, 32'hFFFF_FFFF, 4'b1111);
        rd(8'h0C, "R10");

        // R7: bit 4 unwritable
        wr(8'h0C, 32'h10, 4'b0001);
        rd(8'h0C, "R7");

        // R8: frame msb toggles both ways
        frame_msb = 1; tick(); tick();
        rd(8'h0C, "R8");
        wr(8'h0C, 32'h20, 4'b0001);
        rd(8'h0C, "R8");
        frame_msb = 0; tick();
        rd(8'h0C, "R8");
        wr(8'h0C, 32'h20, 4'b0001);

        // R10: event beats same-cycle clear
        evt_sof = 1; reg_wr = 1; reg_addr = 8'h0C; reg_wdata = 32'h4; reg_be = 4'b0001;
        tick();
        rd(8'h0C, "R10");

        // R11: enable masking
        int_enable = 32'h1; tick(); tick();
        int_enable = 32'h4; tick(); tick();
        wr(8'h0C, 32'h4, 4'b0001);
        tick();
        int_enable = 32'hFFFF_FFFF; evt_resume = 1; tick(); tick();

        finish_run();
    end
endmodule